// File: doc/BRIEF.md
# Byte Parity Generator, Checker and Error Register

This block sits between a bus slave and a word-wide storage array. On every write it computes one odd-parity bit for each 8-bit byte, so each 16-bit word is stored as 18 bits. It also produces a per-byte write strobe for those parity bits, so that a byte write changes only the parity bit of the byte it touches. On every read it checks each byte against the parity bit stored with it. A failing read is recorded in a single control and status register, and this one register governs parity for all of the memory behind the slave.

The register sits at one of sixteen word addresses, chosen by a 4-bit select input. Software sets its report-enable bit. The block sets its sticky error bit and records the high-order bits of the failing address. A report-mode input picks how an error reaches the processor:

- In the first mode, an error raises a trap request that sends the processor to its parity-error vector.
- In the second mode, no trap request is raised. Instead, the slave's acknowledge is held off for the failing read, so the processor takes a bus timeout trap.

A global enable input switches checking off entirely. The bus handshake and the storage array lie outside this block.

Top module: `byte_parity_ctl`

## Requirements
- R1: For each byte i, `par_wr[i]` is the odd-parity bit of `wr_data[8i+7:8i]`: the byte plus the bit holds an odd number of ones. `par_we[i]` equals `wr_en & wr_be[i]`.
- R2: A read fails when `rd_valid` and `par_en` are both 1 and at least one byte, together with its stored bit `rd_par[i]`, holds an even number of ones. When `par_en` is 0, no read fails.
- R3: The register answers only when `bus_addr` equals 772100 octal plus twice `reg_sel`. At any other address, `reg_rdata` is 0 and a write has no effect.
- R4: A register read drives `reg_rdata` in the same cycle. Bit 15 is the sticky error flag, bits 11:5 hold the captured address bits, bit 0 is report enable, and every other bit is 0. Without a read strobe at the register's address, `reg_rdata` is 0.
- R5: A failing read sets the error flag at the next clock edge and loads bits 17:11 of the failing word address (`rd_addr_hi`) into the capture field.
- R6: A register write loads bit 0 of `reg_wdata` into report enable and clears the error flag.
- R7: With `trap_mode` at 0, `par_trap` is 1 exactly while both the error flag and report enable are 1, and `ssyn_inhibit` stays 0.
- R8: With `trap_mode` at 1, `ssyn_inhibit` is 1 in the same cycle as a failing read while report enable is 1, and `par_trap` stays 0.
- R9: When a register write and a failing read occur in the same cycle, the error flag ends up set, report enable takes the written value, and the capture field takes the failing address.
- R10: After reset, report enable, the error flag and the capture field are all 0.
- R11: With report enable at 0, a failing read still sets the flag and captures the address, but it raises neither `par_trap` nor `ssyn_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_en | input | 1 | Global parity check enable |
| trap_mode | input | 1 | 0: raise a trap request; 1: withhold the acknowledge |
| reg_sel | input | 4 | Register word-address select |
| wr_en | input | 1 | Memory write cycle |
| wr_be | input | 2 | Byte enables of the write |
| wr_data | input | 16 | Write data |
| par_wr | output | 2 | Parity bits to store, one per byte |
| par_we | output | 2 | Per-byte write strobe for the parity bits |
| rd_valid | input | 1 | Read data valid from the array |
| rd_addr_hi | input | 7 | Bits 17:11 of the word address being read |
| rd_data | input | 16 | Read data |
| rd_par | input | 2 | Stored parity bits of the read word |
| bus_addr | input | 18 | Bus address for register access |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| par_trap | output | 1 | Parity trap request to the processor |
| ssyn_inhibit | output | 1 | Holds off the slave acknowledge |

## Verification
A processor write to the register and a failing read can land in the same clock cycle. The write clears the error flag, while the failing read sets it and captures the address. The bench drives both in one directed cycle. The random stream also mixes writes to the register's address with corrupted reads, so the two collide again many times. In each collision the reference model expects the flag set and the new address captured, and this is judged by reading the register back in a later cycle. The bench also observes `par_trap` on the cycle after the collision.

// File: rtl/byte_parity_ctl.sv
module byte_parity_ctl #(
  parameter int DW = 16,
  parameter int AW = 18,
  parameter int CAPW = 7,
  parameter logic [AW-1:0] REG_BASE = 18'o772100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            par_en,
  input  logic            trap_mode,
  input  logic [3:0]      reg_sel,
  input  logic            wr_en,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] par_wr,
  output logic [DW/8-1:0] par_we,
  input  logic            rd_valid,
  input  logic [CAPW-1:0] rd_addr_hi,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW/8-1:0] rd_par,
  input  logic [AW-1:0]   bus_addr,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            par_trap,
  output logic            ssyn_inhibit
);
  localparam int NB = DW / 8;
  localparam int CAP_LO = 5;

  logic [NB-1:0]   byte_bad;
  logic            rd_err, reg_hit, wr_hit;
  logic            rpt_en, err_flag;
  logic [CAPW-1:0] cap_addr;
  logic            unused_wdata;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign par_wr[g]   = ~^wr_data[8*g +: 8];
    assign par_we[g]   = wr_en & wr_be[g];
    assign byte_bad[g] = ~^{rd_par[g], rd_data[8*g +: 8]};
  end

  assign rd_err  = rd_valid & par_en & (|byte_bad);
  assign reg_hit = bus_addr == (REG_BASE + (AW'(reg_sel) << 1));
  assign wr_hit  = reg_wr & reg_hit;
  assign unused_wdata = ^reg_wdata[DW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_en   <= 1'b0;
      err_flag <= 1'b0;
      cap_addr <= '0;
    end else begin
      if (wr_hit) begin
        rpt_en   <= reg_wdata[0];
        err_flag <= 1'b0;
      end
      if (rd_err) begin
        err_flag <= 1'b1;
        cap_addr <= rd_addr_hi;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && reg_hit) begin
      reg_rdata[DW-1]                = err_flag;
      reg_rdata[CAP_LO+CAPW-1:CAP_LO] = cap_addr;
      reg_rdata[0]                   = rpt_en;
    end
  end

  assign par_trap     = err_flag & rpt_en & ~trap_mode;
  assign ssyn_inhibit = rd_err & rpt_en & trap_mode;
endmodule

// File: rtl/byte_parity_chk.sv
module byte_parity_chk #(
  parameter int NB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_mode,
  input logic            par_en,
  input logic            rd_valid,
  input logic [8*NB-1:0] rd_data,
  input logic [NB-1:0]   rd_par,
  input logic [NB-1:0]   wr_be,
  input logic [NB-1:0]   par_we,
  input logic            par_trap,
  input logic            ssyn_inhibit,
  input logic            err_flag,
  input logic            rpt_en,
  input logic            wr_hit
);
  logic chk_err;
  always_comb begin
    chk_err = 1'b0;
    for (int i = 0; i < NB; i++)
      if ((^{rd_par[i], rd_data[8*i +: 8]}) == 1'b0) chk_err = 1'b1;
    chk_err = chk_err & rd_valid & par_en;
  end

  AST_WE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (par_we & ~wr_be) == '0); // R1
  AST_INHIBIT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ssyn_inhibit |-> (rd_valid && par_en)); // R2
  AST_ERROR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |=> err_flag); // R5
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !chk_err) |=> !err_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !wr_hit) |=> err_flag); // R5
  AST_TRAP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    par_trap |-> (err_flag && rpt_en && !trap_mode)); // R7
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_trap && ssyn_inhibit)); // R8
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_en |-> (!par_trap && !ssyn_inhibit)); // R11
endmodule

bind byte_parity_ctl byte_parity_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_mode(trap_mode), .par_en(par_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par), .wr_be(wr_be),
  .par_we(par_we), .par_trap(par_trap), .ssyn_inhibit(ssyn_inhibit),
  .err_flag(err_flag), .rpt_en(rpt_en), .wr_hit(wr_hit)
);

// File: tb/byte_parity_ctl_test.sv
module byte_parity_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic par_en, trap_mode, wr_en, rd_valid, reg_rd, reg_wr;
  logic [3:0] reg_sel;
  logic [1:0] wr_be, par_wr, par_we, rd_par;
  logic [15:0] wr_data, rd_data, reg_wdata, reg_rdata;
  logic [6:0] rd_addr_hi;
  logic [17:0] bus_addr;
  logic par_trap, ssyn_inhibit;

  int checks = 0, fails = 0;
  logic m_en = 0, m_flag = 0;
  logic [6:0] m_cap = 0;

  always #2.5 clk = ~clk;

  byte_parity_ctl uut (.*);

  function automatic logic odd_bit(logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(b[i]);
    return (n % 2 == 0);
  endfunction

  function automatic logic exp_err();
    logic bad = 0;
    for (int k = 0; k < 2; k++)
      if (odd_bit(rd_data[8*k +: 8]) != rd_par[k]) bad = 1;
    return bad & rd_valid & par_en;
  endfunction

  function automatic logic exp_hit();
    return bus_addr == 18'o772100 + 18'(reg_sel) * 2;
  endfunction

  task automatic cmp(string tag, string deft, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", (tag == "") ? deft : tag, nm, act, exp);
    end
  endtask

  task automatic idle();
    par_en = 1; trap_mode = 0; wr_en = 0; rd_valid = 0; reg_rd = 0; reg_wr = 0;
    reg_sel = 0; wr_be = 0; wr_data = 0; rd_data = 0; rd_par = 2'b11;
    reg_wdata = 0; rd_addr_hi = 0; bus_addr = 0;
  endtask

  task automatic step(string tag);
    logic e;
    logic [15:0] rv;
    #1;
    e = exp_err();
    rv = 0;
    if (reg_rd && exp_hit()) rv = {m_flag, 3'b000, m_cap, 4'b0000, m_en};
    cmp(tag, "R1", "par_wr", 32'(par_wr), 32'({odd_bit(wr_data[15:8]), odd_bit(wr_data[7:0])}));
    cmp(tag, "R1", "par_we", 32'(par_we), 32'(wr_be & {2{wr_en}}));
    cmp(tag, "R8", "ssyn_inhibit", 32'(ssyn_inhibit), 32'(e & m_en & trap_mode));
    cmp(tag, "R7", "par_trap", 32'(par_trap), 32'(m_flag & m_en & ~trap_mode));
    cmp(tag, "R4", "reg_rdata", 32'(reg_rdata), 32'(rv));
    @(posedge clk);
    if (rst_n) begin
      if (reg_wr && exp_hit()) begin m_en = reg_wdata[0]; m_flag = 0; end
      if (e) begin m_flag = 1; m_cap = rd_addr_hi; end
    end
    @(negedge clk);
  endtask

  task automatic bad_read(logic [6:0] a);
    rd_valid = 1; rd_addr_hi = a; rd_data = 16'h1234;
    rd_par = {odd_bit(8'h12), ~odd_bit(8'h34)};
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    reg_rd = 1; bus_addr = 18'o772100;
    repeat (2) @(negedge clk);
    step("R10");
    rst_n = 1;
    step("R10");
    // R3: select 5 places the register at 772112 octal
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_wr = 1; reg_wdata = 16'h0001;
    step("R6");
    idle(); reg_sel = 5; bus_addr = 18'o772110; reg_rd = 1; reg_wr = 1; reg_wdata = 0;
    step("R3");
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_rd = 1;
    step("R3");
    // R2: checking switched off
    idle(); par_en = 0; bad_read(7'h11);
    step("R2");
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_rd = 1;
    step("R2");
    // R5 and R7: trap mode
    idle(); bad_read(7'h55);
    step("R5");
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_rd = 1;
    step("R7");
    // R9: register write and failing read in one cycle
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_wr = 1; reg_wdata = 16'h0001; bad_read(7'h2A);
    step("R9");
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_rd = 1;
    step("R9");
    // R11: reporting disabled
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_wr = 1; reg_wdata = 0;
    step("R6");
    idle(); trap_mode = 1; bad_read(7'h7F);
    step("R11");
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_rd = 1;
    step("R11");
    // R8: acknowledge withheld
    idle(); reg_sel = 5; bus_addr = 18'o772112; reg_wr = 1; reg_wdata = 16'h0001;
    step("R6");
    idle(); trap_mode = 1; bad_read(7'h03);
    step("R8");
    // R1: byte write patterns
    idle(); wr_en = 1; wr_be = 2'b10; wr_data = 16'hFF00;
    step("R1");
    idle(); wr_en = 1; wr_be = 2'b01; wr_data = 16'h0001;
    step("R1");

    void'($urandom(32'd1976));
    for (int n = 0; n < 4000; n++) begin
      idle();
      par_en = ($urandom % 8) != 0;
      trap_mode = ($urandom % 4) == 0;
      reg_sel = 4'($urandom);
      bus_addr = ($urandom % 2) ? 18'o772100 + 18'(reg_sel) * 2 : 18'o772100 + 18'($urandom % 32);
      reg_rd = $urandom % 2;
      reg_wr = ($urandom % 6) == 0;
      reg_wdata = 16'($urandom);
      wr_en = $urandom % 2; wr_be = 2'($urandom); wr_data = 16'($urandom);
      rd_valid = $urandom % 2; rd_addr_hi = 7'($urandom); rd_data = 16'($urandom);
      rd_par = {odd_bit(rd_data[15:8]), odd_bit(rd_data[7:0])};
      if (($urandom % 4) == 0) rd_par = rd_par ^ 2'(1 + $urandom % 3);
      step("");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule